// File: doc/BRIEF.md
# Clocked Serial Master Receiver

This block is the receive half of a clock-synchronous serial port that runs as clock master. It drives its own serial clock, which idles high and has a period set by a parameter, and it shifts in 8-bit frames from a single data input. The first bit of each frame is the most significant bit. Each bit is sampled on the rising clock edge. A finished byte goes into a data register and raises a full flag. Software reads that register to take the byte.

A read of the data register does two jobs. It takes the held byte, which clears the full flag. When the engine is idle and enabled, it also starts reception, so software begins a stream with a dummy read. Without the stop bit the engine carries on byte after byte. With the stop bit it halts once the byte in progress is done. If a byte completes while the previous one is still unread, the new byte is thrown away and the overrun flag is set. No reception can start until software writes the overrun flag back to zero.

Top module: `sync_rx_master`

## Requirements
- R1: After reset the serial clock is high, the engine is idle, and the full flag, overrun flag, data register and control bits are all zero.
- R2: A data-register read while idle starts reception only when the enable bit (control bit 0) and the master bit (control bit 2) are both 1 and no overrun is pending. With either bit at 0, the read leaves the engine idle.
- R3: While receiving, the serial clock runs low then high, each phase lasting HALF_DIV system clocks. Data is sampled on each rising edge, most significant bit first, 8 bits per frame. While idle the clock stays high.
- R4: When the eighth bit is sampled and the full flag is 0, the byte is written to the data register and the full flag is set.
- R5: A read of the data register clears the full flag.
- R6: A byte that completes while the full flag is 1 is discarded. The held byte stays unchanged, the overrun flag is set, and the engine goes idle.
- R7: While the overrun flag is 1, data-register reads start no reception. Writing the status register with bit 1 at 0 clears the flag.
- R8: With the stop bit (control bit 1) at 0, the engine starts the next frame right after each completed byte without any further read.
- R9: With the stop bit at 1, the engine finishes the frame in progress and then goes idle with the clock high.
- R10: Clearing the enable bit mid-frame lets that frame finish and be stored, then the engine goes idle. The flags are left as they were.
- R11: After a stopped stream ends, a read with the enable bit still 1 starts a new frame. A read with the enable bit 0 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 control, 1 status |
| wr_data | input | 3 | Write data: control bits {master, stop, enable}; for status, bit 1 = 0 clears overrun |
| data_rd | input | 1 | Read strobe of the data register |
| sdi | input | 1 | Serial data in |
| sclk_o | output | 1 | Serial clock out, idles high |
| rx_data_o | output | 8 | Data register |
| full_o | output | 1 | Receive data full flag |
| ovr_o | output | 1 | Overrun flag |
| busy_o | output | 1 | Engine is clocking a frame |
| ctrl_o | output | 3 | Control register contents |

## Verification
The bench stops reading so that a second byte completes onto a full register. A design that overwrote the held byte, failed to flag the loss, or kept clocking would report a wrong byte, a missing flag or a busy engine. It then reads while overrun is pending, which a design that ignored the overrun block would wrongly treat as a start. The stop-bit and enable-clear cases check that the byte in flight still completes and that clocking then ends. A design that aborted mid-frame would lose a byte and leave the serial stream out of step. The bench also reads after the stream ends with enable both on and off, which catches a design that never restarts or always restarts.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int CTRL_W   = 3;
  localparam int CTRL_EN  = 0;
  localparam int CTRL_STP = 1;
  localparam int CTRL_MST = 2;
  localparam int STAT_OVR = 1;

  typedef enum logic {ST_IDLE = 1'b0, ST_SHIFT = 1'b1} rx_state_t;
endpackage

// File: rtl/sync_rx_clkgen.sv
module sync_rx_clkgen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk_q,
  output logic rise_now
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = (cnt == CW'(HALF_DIV - 1));
  assign rise_now = run && wrap && !sclk_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt    <= '0;
      sclk_q <= 1'b1;
    end else if (wrap) begin
      cnt    <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sync_rx_shifter.sv
module sync_rx_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         sample,
  input  logic         sdi,
  output logic         done,
  output logic [W-1:0] word
);
  localparam int BW = (W > 1) ? $clog2(W) : 1;
  logic [BW-1:0] bcnt;
  logic [W-2:0]  sreg;

  assign done = sample && (bcnt == BW'(W - 1));
  assign word = {sreg, sdi};

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      bcnt <= '0;
      sreg <= '0;
    end else if (sample) begin
      bcnt <= done ? '0 : bcnt + 1'b1;
      sreg <= word[W-2:0];
    end
  end
endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master
  import sync_rx_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int W        = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              data_rd,
  input  logic              sdi,
  output logic              sclk_o,
  output logic [W-1:0]      rx_data_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              busy_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  rx_state_t   state;
  logic [CTRL_W-1:0] ctrl_q;
  logic        run, rise, done, lost, take, start;
  logic [W-1:0] word;

  assign run    = (state == ST_SHIFT);
  assign busy_o = run;
  assign ctrl_o = ctrl_q;
  assign lost   = done && full_o && !data_rd;
  assign take   = done && !lost;
  assign start  = (state == ST_IDLE) && data_rd && !ovr_o &&
                  ctrl_q[CTRL_EN] && ctrl_q[CTRL_MST];

  sync_rx_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst(rst), .run(run), .sclk_q(sclk_o), .rise_now(rise)
  );

  sync_rx_shifter #(.W(W)) u_shf (
    .clk(clk), .rst(rst), .run(run), .sample(rise), .sdi(sdi),
    .done(done), .word(word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (reg_wr && !reg_sel) begin
      ctrl_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else if (start) begin
      state <= ST_SHIFT;
    end else if (done && (lost || ctrl_q[CTRL_STP] || !ctrl_q[CTRL_EN])) begin
      state <= ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data_o <= '0;
      full_o    <= 1'b0;
      ovr_o     <= 1'b0;
    end else begin
      if (take) begin
        rx_data_o <= word;
        full_o    <= 1'b1;
      end else if (data_rd) begin
        full_o <= 1'b0;
      end
      if (lost) begin
        ovr_o <= 1'b1;
      end else if (reg_wr && reg_sel && !wr_data[STAT_OVR]) begin
        ovr_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sync_rx_master_chk.sv
module sync_rx_master_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         data_rd,
  input logic         sclk_o,
  input logic [W-1:0] rx_data_o,
  input logic         full_o,
  input logic         ovr_o,
  input logic         busy_o,
  input logic [2:0]   ctrl_o
);
  assert_idle_clock_high_R3: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> sclk_o);

  assert_clock_moves_only_busy_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(sclk_o) |-> $past(busy_o));

  assert_read_clears_full_R5: assert property (@(posedge clk) disable iff (rst)
    (data_rd && full_o && !busy_o) |=> !full_o);

  assert_overrun_keeps_data_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_o) |-> ($stable(rx_data_o) && full_o && !busy_o));

  assert_start_needs_clean_enable_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(!ovr_o && ctrl_o[0] && ctrl_o[2] && data_rd));

  assert_stop_goes_idle_R9: assert property (@(posedge clk) disable iff (rst)
    ($rose(full_o) && $past(ctrl_o[1])) |-> !busy_o);
endmodule

bind sync_rx_master sync_rx_master_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .data_rd(data_rd), .sclk_o(sclk_o),
  .rx_data_o(rx_data_o), .full_o(full_o), .ovr_o(ovr_o),
  .busy_o(busy_o), .ctrl_o(ctrl_o)
);

// File: tb/sync_rx_master_tb.sv
module sync_rx_master_tb;
  localparam int HALF = 4;
  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0, reg_sel = 1'b0, data_rd = 1'b0, sdi = 1'b0;
  logic [2:0] wr_data = '0;
  logic sclk_o, full_o, ovr_o, busy_o;
  logic [7:0] rx_data_o;
  logic [2:0] ctrl_o;
  int tests = 0, fails = 0;
  int next_frame = 0, slv_frame = 0, slv_bit = 0;
  logic [7:0] slv_byte = '0;
  logic [7:0] exp_q[$];
  logic prev_full = 1'b0;

  always #2 clk = ~clk;

  sync_rx_master #(.HALF_DIV(HALF), .W(8)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .wr_data(wr_data),
    .data_rd(data_rd), .sdi(sdi), .sclk_o(sclk_o), .rx_data_o(rx_data_o),
    .full_o(full_o), .ovr_o(ovr_o), .busy_o(busy_o), .ctrl_o(ctrl_o)
  );

  function automatic logic [7:0] pat(input int k);
    return 8'(k * 53 + 150);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // slave: shifts the next frame byte out on each falling serial clock
  always @(negedge sclk_o) begin
    if (!rst) begin
      if (slv_bit == 0) slv_byte = pat(slv_frame);
      sdi <= slv_byte[7 - slv_bit];
      if (slv_bit == 7) begin
        slv_bit = 0;
        slv_frame++;
      end else begin
        slv_bit++;
      end
    end
  end

  // scoreboard monitor: every new full byte must match the queue head (R4)
  always @(negedge clk) begin
    if (!rst && full_o && !prev_full) begin
      if (exp_q.size() == 0) chk("R4 unexpected byte", rx_data_o, -1);
      else chk("R4 byte", rx_data_o, exp_q.pop_front());
    end
    prev_full <= full_o;
  end

  task automatic expect_frame(input bit keep);
    if (keep) exp_q.push_back(pat(next_frame));
    next_frame++;
  endtask

  task automatic wr(input logic sel, input logic [2:0] d);
    @(posedge clk); reg_wr <= 1'b1; reg_sel <= sel; wr_data <= d;
    @(posedge clk); reg_wr <= 1'b0;
    @(negedge clk);
  endtask

  task automatic rd();
    @(posedge clk); data_rd <= 1'b1;
    @(posedge clk); data_rd <= 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_full();
    while (!full_o) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst <= 1'b0;
    @(negedge clk);
    chk("R1 sclk", sclk_o, 1); chk("R1 busy", busy_o, 0);
    chk("R1 full", full_o, 0); chk("R1 ovr", ovr_o, 0);
    chk("R1 data", rx_data_o, 0); chk("R1 ctrl", ctrl_o, 0);

    // R2: no start without enable or without master
    wr(0, 3'b100); rd(); repeat (2 * HALF) @(negedge clk);
    chk("R2 no enable", busy_o, 0); chk("R2 sclk idle", sclk_o, 1);
    wr(0, 3'b001); rd(); repeat (2 * HALF) @(negedge clk);
    chk("R2 no master", busy_o, 0);

    // R9: single byte with stop set, R3 timing
    wr(0, 3'b111); expect_frame(1); rd();
    chk("R2 start", busy_o, 1);
    begin
      int lo = 0;
      while (sclk_o) @(negedge clk);
      while (!sclk_o) begin lo++; @(negedge clk); end
      chk("R3 low phase", lo, HALF);
    end
    wait_full();
    chk("R9 idle after byte", busy_o, 0); chk("R9 sclk high", sclk_o, 1);
    // R11: read with enable still set restarts
    expect_frame(1); rd();
    chk("R5 full cleared", full_o, 0); chk("R11 restart", busy_o, 1);
    wait_full();
    wr(0, 3'b100); rd();
    chk("R5 full cleared", full_o, 0);
    repeat (2 * HALF) @(negedge clk);
    chk("R11 no restart", busy_o, 0);

    // R8 continuous, R10 enable cleared mid-frame
    wr(0, 3'b101);
    expect_frame(1); expect_frame(1); expect_frame(1);
    rd();
    wait_full(); chk("R8 continues", busy_o, 1); rd();
    wait_full(); rd();
    wr(0, 3'b100);
    chk("R10 frame in flight", busy_o, 1);
    wait_full();
    chk("R10 idle", busy_o, 0);
    repeat (4 * HALF) @(negedge clk);
    chk("R10 full kept", full_o, 1); chk("R10 ovr kept", ovr_o, 0);
    rd();

    // R6 / R7 overrun
    wr(0, 3'b101);
    expect_frame(1); expect_frame(0);
    rd();
    wait_full();
    while (!ovr_o) @(negedge clk);
    chk("R6 held byte", rx_data_o, pat(next_frame - 2));
    chk("R6 full", full_o, 1);
    chk("R6 idle", busy_o, 0);
    rd(); repeat (2 * HALF) @(negedge clk);
    chk("R7 blocked", busy_o, 0);
    wr(1, 3'b010);
    chk("R7 write 1 ignored", ovr_o, 1);
    wr(1, 3'b000);
    chk("R7 cleared", ovr_o, 0);
    wr(0, 3'b111); expect_frame(1); rd();
    chk("R7 restart", busy_o, 1);
    wait_full();
    wr(0, 3'b100); rd();
    repeat (4) @(negedge clk);
    chk("R4 queue drained", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule